// File: doc/BRIEF.md
# Dual-I/O Fast-Read Flash Responder

This block is the device side of a serial flash that serves a single instruction: a fast read that moves the address and the data two bits per serial clock. The serial pins are slow compared with the system clock. The block passes them through synchronizer flops and finds the serial clock edges by comparing successive samples. The host lowers chip select and sends an 8-bit opcode on IO0. It then sends a 24-bit address as twelve bit pairs and four dummy clocks. After that the block takes over both IO lines and streams bytes two bits per clock until chip select rises.

The bytes come from a memory array through a plain read port: the block presents a 23-bit address, and the byte appears on the data input one system clock later. The next byte is requested while the last bit pair of the current byte is on the lines, so the stream has no gap between bytes. The pointer wraps from the top of the 8 MiB space back to zero. Any other opcode makes the block stay silent until chip select rises.

Top module: `dual_io_read_slave`

## Requirements
- R1: While reset is high and on the first clock after it, both output enables and both output bits are 0 and `mem_addr` is 0.
- R2: The opcode is taken from `io0_in` only, MSB first, on eight rising SCK edges. `io1_in` is ignored during the opcode. Only the value 0xBB starts a read. Any other value keeps both enables low for the rest of the transaction, whatever SCK does.
- R3: The next twelve rising edges carry the address as bit pairs, most significant pair first. In each pair, `io1_in` holds the odd bit and `io0_in` the even bit. Bit 23 is discarded and bits 22..0 select the byte.
- R4: Four dummy clocks follow the address. The values on both IO inputs during these clocks have no effect on the data returned.
- R5: Data changes only on falling SCK edges, starting with the falling edge of the last dummy clock. Each byte takes four falls, MSB pair first. `io1_out` carries bits 7,5,3,1 and `io0_out` carries bits 6,4,2,0. The first byte is the one at the received address.
- R6: While chip select stays low, consecutive bytes follow at consecutive addresses with no idle clocks between them.
- R7: The byte after address 0x7FFFFF comes from address 0x000000.
- R8: Both output enables stay low through the opcode, address and dummy phases. They rise together on the first data falling edge, and while they are low both output bits are 0.
- R9: A rise of chip select at any point clears both enables and both outputs within four system clocks. The next transaction is then decoded from its first opcode bit.
- R10: The block works in SPI mode 0 (SCK idles low) and mode 3 (SCK idles high). The first falling edge in mode 3 has no effect.
- R11: The block requests each byte by placing its address on `mem_addr` and takes `mem_rdata` one system clock later. After N whole bytes have been sent, `mem_addr` holds the start address plus N, modulo 2^23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| sck_pin | input | 1 | Serial clock from the host |
| cs_n_pin | input | 1 | Active-low chip select |
| io0_in | input | 1 | IO0 pad input |
| io1_in | input | 1 | IO1 pad input |
| io0_out | output | 1 | IO0 pad output value |
| io0_oe | output | 1 | IO0 pad output enable |
| io1_out | output | 1 | IO1 pad output value |
| io1_oe | output | 1 | IO1 pad output enable |
| mem_addr | output | 23 | Array read address |
| mem_rdata | input | 8 | Array read data, one clock after the address |

## Verification
The assertions assume that chip select and the IO inputs change only while SCK is stable. They also assume that each SCK half period lasts at least four system clocks, which leaves time for synchronization and for the array fetch. Given those limits, the enable-release check may count a fixed number of system clocks after chip select goes high. The bench holds every SCK level for eight system clocks. It changes IO inputs only together with a falling SCK, or while SCK is idle, and it samples the outputs just before the next rising SCK edge.

// File: rtl/dio_pkg.sv
package dio_pkg;

  // Transaction phases, decoded from the serial stream
  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } dio_state_t;

  localparam logic [7:0] OPC_DUAL_READ = 8'hBB;
  localparam int         OPC_BITS      = 8;
  localparam int         BYTE_W        = 8;
  localparam int         PAIRS_PER_BYTE = BYTE_W / 2;

  // Bit positions inside the synchronized pin vector
  localparam int PIN_SCK = 0;
  localparam int PIN_CS  = 1;
  localparam int PIN_IO0 = 2;
  localparam int PIN_IO1 = 3;

endpackage

// File: rtl/dio_pin_sync.sv
module dio_pin_sync #(
  parameter int         STAGES  = 2,
  parameter int         W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_in,
  output logic [W-1:0] pins_s,
  output logic         sck_rise,
  output logic         sck_fall
);

  logic [STAGES-1:0][W-1:0] pipe;
  logic                     sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe  <= {STAGES{RST_VAL}};
      sck_d <= RST_VAL[0];
    end else begin
      pipe  <= {pipe[STAGES-2:0], pins_in};
      sck_d <= pipe[STAGES-1][0];
    end
  end

  assign pins_s   = pipe[STAGES-1];
  assign sck_rise =  pipe[STAGES-1][0] & ~sck_d;
  assign sck_fall = ~pipe[STAGES-1][0] &  sck_d;

endmodule

// File: rtl/dio_ctrl.sv
module dio_ctrl
  import dio_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int MEM_AW     = 23,
  parameter int DUMMY_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              io0_s,
  input  logic              io1_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  output logic              load_addr,
  output logic [MEM_AW-1:0] addr_val,
  output logic              shift_en,
  output logic              first_pair,
  output logic              advance
);

  localparam int ADDR_PAIRS = ADDR_W / 2;
  localparam int CNT_W      = $clog2(ADDR_PAIRS + 1);
  localparam int PAIR_W     = $clog2(PAIRS_PER_BYTE);

  dio_state_t              state;
  logic [CNT_W-1:0]        cnt;
  logic [PAIR_W-1:0]       pair;
  logic [OPC_BITS-2:0]     opc;
  logic [MEM_AW-3:0]       addr_sr;
  logic [OPC_BITS-1:0]     opc_full;

  assign opc_full   = {opc, io0_s};
  // older pairs shift out of the top, so only the low MEM_AW bits survive
  assign addr_val   = {addr_sr, io1_s, io0_s};
  assign load_addr  = (state == ST_ADDR) && sck_rise && (cnt == CNT_W'(ADDR_PAIRS - 1));
  assign shift_en   = (state == ST_DATA) && sck_fall;
  assign first_pair = (pair == '0);
  assign advance    = shift_en && (pair == PAIR_W'(PAIRS_PER_BYTE - 1));

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      state   <= ST_CMD;
      cnt     <= '0;
      pair    <= '0;
      opc     <= '0;
      addr_sr <= '0;
    end else begin
      case (state)
        ST_CMD: if (sck_rise) begin
          opc <= opc_full[OPC_BITS-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(OPC_BITS - 1)) begin
            cnt   <= '0;
            state <= (opc_full == OPC_DUAL_READ) ? ST_ADDR : ST_SKIP;
          end
        end
        ST_ADDR: if (sck_rise) begin
          addr_sr <= addr_val[MEM_AW-3:0];
          cnt     <= cnt + 1'b1;
          if (load_addr) begin
            cnt   <= '0;
            state <= ST_DUMMY;
          end
        end
        ST_DUMMY: if (sck_rise) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
            cnt   <= '0;
            pair  <= '0;
            state <= ST_DATA;
          end
        end
        ST_DATA: if (sck_fall) pair <= pair + 1'b1;
        default: state <= ST_SKIP;
      endcase
    end
  end

endmodule

// File: rtl/dio_fetch.sv
module dio_fetch
  import dio_pkg::*;
#(
  parameter int MEM_AW = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_addr,
  input  logic [MEM_AW-1:0] addr_val,
  input  logic              advance,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [BYTE_W-1:0] next_byte
);

  logic [MEM_AW-1:0] ptr;
  logic              req, req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      req       <= 1'b0;
      req_d     <= 1'b0;
      next_byte <= '0;
    end else begin
      req   <= 1'b0;
      req_d <= req;
      if (load_addr) begin
        ptr <= addr_val;
        req <= 1'b1;
      end else if (advance) begin
        ptr <= ptr + 1'b1;   // natural wrap at 2**MEM_AW
        req <= 1'b1;
      end
      if (req_d) next_byte <= mem_rdata;
    end
  end

  assign mem_addr = ptr;

endmodule

// File: rtl/dio_out_shift.sv
module dio_out_shift
  import dio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              first_pair,
  input  logic [BYTE_W-1:0] next_byte,
  output logic              io0_out,
  output logic              io0_oe,
  output logic              io1_out,
  output logic              io1_oe
);

  logic [BYTE_W-1:0] sr;
  logic [BYTE_W-1:0] src;

  assign src = first_pair ? next_byte : sr;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr      <= '0;
      io0_out <= 1'b0;
      io1_out <= 1'b0;
      io0_oe  <= 1'b0;
      io1_oe  <= 1'b0;
    end else if (shift_en) begin
      io1_out <= src[BYTE_W-1];
      io0_out <= src[BYTE_W-2];
      sr      <= {src[BYTE_W-3:0], 2'b00};
      io0_oe  <= 1'b1;
      io1_oe  <= 1'b1;
    end
  end

endmodule

// File: rtl/dual_io_read_slave.sv
module dual_io_read_slave
  import dio_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int MEM_AW      = 23,
  parameter int DUMMY_CLKS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_pin,
  input  logic              cs_n_pin,
  input  logic              io0_in,
  input  logic              io1_in,
  output logic              io0_out,
  output logic              io0_oe,
  output logic              io1_out,
  output logic              io1_oe,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata
);

  localparam int PIN_W = 4;
  localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << PIN_CS;

  logic [PIN_W-1:0]  pins_s;
  logic              sck_rise, sck_fall;
  logic              load_addr, shift_en, first_pair, advance;
  logic [MEM_AW-1:0] addr_val;
  logic [BYTE_W-1:0] next_byte;

  dio_pin_sync #(.STAGES(SYNC_STAGES), .W(PIN_W), .RST_VAL(PIN_RST)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pins_in  ({io1_in, io0_in, cs_n_pin, sck_pin}),
    .pins_s   (pins_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  dio_ctrl #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DUMMY_CLKS(DUMMY_CLKS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cs_n_s     (pins_s[PIN_CS]),
    .io0_s      (pins_s[PIN_IO0]),
    .io1_s      (pins_s[PIN_IO1]),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .load_addr  (load_addr),
    .addr_val   (addr_val),
    .shift_en   (shift_en),
    .first_pair (first_pair),
    .advance    (advance)
  );

  dio_fetch #(.MEM_AW(MEM_AW)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .load_addr (load_addr),
    .addr_val  (addr_val),
    .advance   (advance),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .next_byte (next_byte)
  );

  dio_out_shift u_out (
    .clk        (clk),
    .rst        (rst),
    .clear      (pins_s[PIN_CS]),
    .shift_en   (shift_en),
    .first_pair (first_pair),
    .next_byte  (next_byte),
    .io0_out    (io0_out),
    .io0_oe     (io0_oe),
    .io1_out    (io1_out),
    .io1_oe     (io1_oe)
  );

endmodule

// File: rtl/dio_read_checker.sv
module dio_read_checker #(
  parameter int MEM_AW = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n_pin,
  input logic              io0_out,
  input logic              io0_oe,
  input logic              io1_out,
  input logic              io1_oe,
  input logic [MEM_AW-1:0] mem_addr
);

  // R1: reset leaves the pads released and the pointer at zero
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!io0_oe && !io1_oe && !io0_out && !io1_out && mem_addr == '0));

  // R8: the two lanes are enabled and released as one
  assert_oe_pair_R8: assert property (@(posedge clk) disable iff (rst)
    io0_oe == io1_oe);

  // R8: a released lane carries no stale data
  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !io0_oe |-> (!io0_out && !io1_out));

  // R9: chip select high for four clocks guarantees release
  assert_cs_release_R9: assert property (@(posedge clk) disable iff (rst)
    (cs_n_pin && $past(cs_n_pin, 1) && $past(cs_n_pin, 2) && $past(cs_n_pin, 3)
     && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
    |-> (!io0_oe && !io1_oe));

  // R6 / R7: while streaming, the pointer only steps by one (mod 2**MEM_AW)
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (io0_oe && $past(io0_oe) && mem_addr != $past(mem_addr))
    |-> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

bind dual_io_read_slave dio_read_checker #(.MEM_AW(MEM_AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n_pin (cs_n_pin),
  .io0_out  (io0_out),
  .io0_oe   (io0_oe),
  .io1_out  (io1_out),
  .io1_oe   (io1_oe),
  .mem_addr (mem_addr)
);

// File: tb/sim_dual_io_read_slave.sv
module sim_dual_io_read_slave;

  localparam int H      = 8;   // system clocks per SCK level
  localparam int MEM_AW = 23;
  localparam int NVEC   = 6;

  // {mode3, byte count, 24-bit address}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 4'd3, 24'h000000},
    {1'b1, 4'd4, 24'h123456},
    {1'b0, 4'd2, 24'hABCDEF},
    {1'b1, 4'd3, 24'h7FFFFE},
    {1'b0, 4'd5, 24'h555555},
    {1'b1, 4'd2, 24'h2AAAAA}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck_pin = 1'b0, cs_n_pin = 1'b1, io0_in = 1'b0, io1_in = 1'b0;
  logic io0_out, io0_oe, io1_out, io1_oe;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0] mem_rdata;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  bit  oe_seen;

  always #10 clk = ~clk;

  dual_io_read_slave u0 (
    .clk(clk), .rst(rst), .sck_pin(sck_pin), .cs_n_pin(cs_n_pin),
    .io0_in(io0_in), .io1_in(io1_in),
    .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_f(input logic [MEM_AW-1:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ {1'b0, a[22:16]} ^ 8'hA5;
  endfunction

  // array model: one-clock read latency
  always_ff @(posedge clk) mem_rdata <= mem_f(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_in(input logic b1, input logic b0);
    @(negedge clk);
    sck_pin = 1'b0; io1_in = b1; io0_in = b0;
    wait_n(H);
    oe_seen = oe_seen | io0_oe | io1_oe;
    sck_pin = 1'b1;
    wait_n(H);
  endtask

  task automatic pulse_out(output logic [1:0] pr);
    @(negedge clk);
    sck_pin = 1'b0; io1_in = 1'b0; io0_in = 1'b0;
    wait_n(H);
    pr = {io1_out, io0_out};
    sck_pin = 1'b1;
    wait_n(H);
  endtask

  task automatic transact(input logic [23:0] a, input bit m3, input logic [7:0] op,
                          input int nb, input int extra);
    logic [1:0] pr;
    logic [7:0] bytev;
    logic [MEM_AW-1:0] ea;
    bit good;
    good = (op == 8'hBB);
    oe_seen = 1'b0;
    @(negedge clk);
    sck_pin = m3; cs_n_pin = 1'b1;
    wait_n(H);
    cs_n_pin = 1'b0;
    wait_n(H);
    for (int i = 7; i >= 0; i--) pulse_in(~op[i], op[i]);      // io1 junk
    for (int k = 11; k >= 0; k--) pulse_in(a[2*k+1], a[2*k]);
    pulse_in(1'b1, 1'b0); pulse_in(1'b0, 1'b1);                 // R4 junk dummy
    pulse_in(1'b1, 1'b1); pulse_in(1'b1, 1'b0);
    chk(!oe_seen, "R8 enables low during opcode/address/dummy", {31'd0, oe_seen}, 0);
    for (int j = 0; j < nb; j++) begin
      bytev = '0;
      for (int p = 0; p < 4; p++) begin
        pulse_out(pr);
        bytev[7-2*p] = pr[1];
        bytev[6-2*p] = pr[0];
        if (good && j == 0 && p == 0)
          chk(io0_oe && io1_oe, "R8 both enables at first data fall", {30'd0, io1_oe, io0_oe}, 3);
        if (!good)
          chk(!io0_oe && !io1_oe, "R2 bad opcode keeps lines released", {30'd0, io1_oe, io0_oe}, 0);
      end
      if (good) begin
        ea = a[MEM_AW-1:0] + MEM_AW'(j);
        chk(bytev == mem_f(ea),
            (ea < a[MEM_AW-1:0]) ? "R7 wrap R5 data byte" :
            (m3 ? "R3 R4 R5 R6 R10 data byte mode3" : "R3 R4 R5 R6 data byte mode0"),
            {24'd0, bytev}, {24'd0, mem_f(ea)});
      end
    end
    if (good && extra == 0)
      chk(mem_addr == a[MEM_AW-1:0] + MEM_AW'(nb), "R11 array pointer after stream",
          {9'd0, mem_addr}, {9'd0, a[MEM_AW-1:0] + MEM_AW'(nb)});
    for (int e = 0; e < extra; e++) pulse_out(pr);
    if (!m3) begin
      @(negedge clk); sck_pin = 1'b0; wait_n(H);
    end
    @(negedge clk);
    cs_n_pin = 1'b1;
    wait_n(4);
    chk(!io0_oe && !io1_oe && !io0_out && !io1_out, "R9 release after chip select high",
        {28'd0, io1_oe, io0_oe, io1_out, io0_out}, 0);
    wait_n(H);
  endtask

  initial begin
    wait_n(5);
    chk(!io0_oe && !io1_oe && !io0_out && !io1_out && mem_addr == '0, "R1 state during reset",
        {28'd0, io1_oe, io0_oe, io1_out, io0_out}, 0);
    @(negedge clk); rst = 1'b0;
    wait_n(2);
    chk(!io0_oe && !io1_oe && mem_addr == '0, "R1 state after reset",
        {9'd0, mem_addr}, 0);

    // vector table
    for (int v = 0; v < NVEC; v++)
      transact(VEC[v][23:0], VEC[v][28], 8'hBB, int'(VEC[v][27:24]), 0);

    // R2: unknown opcode ignored, then a clean read recovers
    transact(24'h001000, 1'b0, 8'h3B, 2, 0);
    transact(24'h001000, 1'b0, 8'hBB, 2, 0);
    transact(24'h0000AA, 1'b1, 8'hBA, 1, 0);

    // R7 / R3: top address bit discarded and wrap from the last byte
    transact(24'hFFFFFF, 1'b0, 8'hBB, 3, 0);

    // R9: abort in the middle of a byte, then read again
    transact(24'h400010, 1'b0, 8'hBB, 1, 2);
    transact(24'h400010, 1'b1, 8'hBB, 2, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule